// File: doc/BRIEF.md
# Programmable Asynchronous Serial Port

A single-channel asynchronous serial port with a byte-wide register bus, a line control register and a 16-bit baud divisor. The divisor produces an enable at sixteen times the bit rate. This enable paces both the transmit shifter and the receive sampler.

Software selects the following through the line control register:
- the data length, from 5 to 8 bits;
- parity: none, odd, even, or a constant level;
- the stop length, which is 1, 1.5 or 2 bits;
- a silence bit, which drives the line low while the transmitter keeps running;
- a switch that points two bus addresses at the divisor bytes.

Received bytes are held in a buffer. A status register reports data ready, parity and framing errors, and the transmitter's empty states.

Register map (byte addresses): 0 = receive buffer on read and transmit holding register on write, or the divisor low byte when the access switch is set. 1 = interrupt control storage, or the divisor high byte when the access switch is set. 3 = line control. 5 = line status. Other addresses read as 0.

Top module: `uart_line`

## Requirements
- R1: A frame is a low start bit, then the data bits least significant bit first, then the optional parity bit, then the high stop bits. Line control bits [1:0] select the data length: 00=5, 01=6, 10=7, 11=8.
- R2: When line control bit 2 is 0, the transmitter sends 1 stop bit. When bit 2 is 1, it sends 1.5 stop bits for 5-bit data and 2 stop bits for any other length.
- R3: The divisor (1 to 65535, where 0 acts as 1) sets one bit time to 16 × divisor clock cycles for both the transmitter and the receiver.
- R4: While line control bit 7 is 1, addresses 0 and 1 read and write the divisor low and high bytes, and no byte is transmitted. While bit 7 is 0, address 1 reads and writes an 8-bit storage register, and the divisor keeps its value.
- R5: With parity enabled (bit 3) and fixed parity (bit 5) clear, the parity bit makes the count of ones in the data and parity bits even when bit 4 is 1, and odd when bit 4 is 0.
- R6: With bits 3 and 5 both set, the parity bit is the constant NOT bit4, both when sent and when checked.
- R7: Line control bit 6 forces the serial output low. The frame in progress still completes with its normal timing.
- R8: After a falling edge, the receiver re-samples the line 8 ticks later. A low pulse shorter than that starts no frame.
- R9: Status bit 2 flags a received parity mismatch, and status bit 3 flags a low first stop bit. A read of address 5 clears both flags.
- R10: Status bit 5 is 1 when the holding register is empty. Status bit 6 is 1 when the holding register and the shifter are both idle.
- R11: A byte written while the shifter is busy waits in the holding register and is sent right after the current frame.
- R12: A completed frame stores its data, zero-extended, in the receive buffer and sets status bit 0. A read of address 0 with bit 7 clear clears status bit 0.
- R13: After reset, line control reads 0x00, status reads 0x60, the divisor is 1 and the serial output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; side effects occur at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| rx_i | input | 1 | Serial input, asynchronous |
| tx_o | output | 1 | Serial output |

## Verification
The hardest cases to reach from the ports are the receive error paths, and above all a framing error.

For a framing error, the line is still low after the stop-bit sample. The receiver must start a new frame on that level and then reject it, without storing a second byte. The bench holds the stop bit low for only 12 of its 16 ticks, so the sample sees 0 and the tail is shorter than the start confirmation.

Parity errors are injected by inverting the computed parity bit, including the fixed-level modes.

The silence mode is checked by timing the empty flag against the expected frame length while the line stays low.

// File: rtl/uart_line_pkg.sv
package uart_line_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } frame_st_e;

  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       multi_stop;
    logic [1:0] len;
  } frame_cfg_t;

  typedef struct packed {
    logic       dlab;
    logic       silence;
    frame_cfg_t fmt;
  } lcr_t;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_LCR  = 3'd3;
  localparam logic [2:0] ADDR_LSR  = 3'd5;

  // parity over the active data bits; fixed mode sends the inverse of 'even'
  function automatic logic par_bit(logic [1:0] len, logic even, logic stick,
                                   logic [7:0] d);
    logic [7:0] m;
    m = 8'hFF >> (2'd3 - len);
    if (stick) return ~even;
    return even ? ^(d & m) : ~^(d & m);
  endfunction

endpackage

// File: rtl/uart_line_baud.sv
module uart_line_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] term;

  assign term   = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt_q >= term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i || tick_o)    cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_i && div_i > 1) |=> !tick_o);

endmodule

// File: rtl/uart_line_tx.sv
module uart_line_tx
  import uart_line_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  frame_cfg_t cfg_i,
  input  logic       silence_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       line_o,
  output logic       thr_empty_o,
  output logic       tx_empty_o
);

  localparam int SUB_W = $clog2(2 * OVS);
  localparam logic [SUB_W-1:0] BIT_LAST    = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] STOP15_LAST = SUB_W'(OVS + OVS / 2 - 1);
  localparam logic [SUB_W-1:0] STOP2_LAST  = SUB_W'(2 * OVS - 1);

  frame_st_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [2:0]       bit_q;
  logic [7:0]       shreg_q;
  logic             par_q;
  logic [7:0]       thr_q;
  logic             thr_full_q;
  logic [SUB_W-1:0] stop_last;
  logic [2:0]       data_last;
  logic             raw_line;

  assign stop_last = !cfg_i.multi_stop ? BIT_LAST :
                     (cfg_i.len == 2'd0) ? STOP15_LAST : STOP2_LAST;
  assign data_last = 3'd4 + {1'b0, cfg_i.len};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sub_q      <= '0;
      bit_q      <= '0;
      shreg_q    <= '0;
      par_q      <= 1'b0;
      thr_q      <= '0;
      thr_full_q <= 1'b0;
    end else begin
      if (state_q == ST_IDLE && thr_full_q) begin
        state_q    <= ST_START;
        sub_q      <= '0;
        shreg_q    <= thr_q;
        par_q      <= par_bit(cfg_i.len, cfg_i.even, cfg_i.stick, thr_q);
        thr_full_q <= 1'b0;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: ;
          ST_START: begin
            if (sub_q == BIT_LAST) begin
              state_q <= ST_DATA;
              sub_q   <= '0;
              bit_q   <= '0;
            end else sub_q <= sub_q + 1'b1;
          end
          ST_DATA: begin
            if (sub_q == BIT_LAST) begin
              sub_q   <= '0;
              shreg_q <= shreg_q >> 1;
              if (bit_q == data_last) state_q <= cfg_i.par_en ? ST_PAR : ST_STOP;
              else                    bit_q   <= bit_q + 1'b1;
            end else sub_q <= sub_q + 1'b1;
          end
          ST_PAR: begin
            if (sub_q == BIT_LAST) begin
              state_q <= ST_STOP;
              sub_q   <= '0;
            end else sub_q <= sub_q + 1'b1;
          end
          ST_STOP: begin
            if (sub_q == stop_last) state_q <= ST_IDLE;
            else                    sub_q   <= sub_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
      if (wr_i) begin
        thr_q      <= wdata_i;
        thr_full_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: raw_line = 1'b0;
      ST_DATA:  raw_line = shreg_q[0];
      ST_PAR:   raw_line = par_q;
      default:  raw_line = 1'b1;
    endcase
  end

  // silence masks the pin only; the shifter above runs regardless
  assign line_o      = raw_line & ~silence_i;
  assign thr_empty_o = ~thr_full_q;
  assign tx_empty_o  = ~thr_full_q & (state_q == ST_IDLE);

  assert_load_next_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && thr_full_q) |=> (state_q == ST_START));

  assert_hold_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_full_q && state_q != ST_IDLE) |=> thr_full_q);

  assert_par_after_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAR) |-> ($past(state_q) == ST_DATA || $past(state_q) == ST_PAR));

endmodule

// File: rtl/uart_line_rx.sv
module uart_line_rx
  import uart_line_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       even_i,
  input  logic       stick_i,
  input  logic       clr_dr_i,
  input  logic       clr_err_i,
  output logic [7:0] data_o,
  output logic       dr_o,
  output logic       pe_o,
  output logic       fe_o
);

  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] BIT_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] MID_LAST = SUB_W'(OVS / 2 - 1);

  logic             s1_q, rx_s;
  frame_st_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [2:0]       bit_q;
  logic [7:0]       sr_q;
  logic             pe_pend_q;
  logic [7:0]       data_q;
  logic             dr_q, pe_q, fe_q;
  logic [2:0]       data_last;
  logic [7:0]       aligned;

  assign data_last = 3'd4 + {1'b0, len_i};
  assign aligned   = sr_q >> (2'd3 - len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      s1_q <= rx_i;
      rx_s <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sub_q     <= '0;
      bit_q     <= '0;
      sr_q      <= '0;
      pe_pend_q <= 1'b0;
      data_q    <= '0;
      dr_q      <= 1'b0;
      pe_q      <= 1'b0;
      fe_q      <= 1'b0;
    end else begin
      if (clr_dr_i) dr_q <= 1'b0;
      if (clr_err_i) begin
        pe_q <= 1'b0;
        fe_q <= 1'b0;
      end
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rx_s) begin
              state_q <= ST_START;
              sub_q   <= '0;
            end
          end
          ST_START: begin
            if (sub_q == MID_LAST) begin
              sub_q <= '0;
              if (!rx_s) begin
                state_q   <= ST_DATA;
                bit_q     <= '0;
                pe_pend_q <= 1'b0;
              end else state_q <= ST_IDLE;
            end else sub_q <= sub_q + 1'b1;
          end
          ST_DATA: begin
            if (sub_q == BIT_LAST) begin
              sub_q <= '0;
              sr_q  <= {rx_s, sr_q[7:1]};
              if (bit_q == data_last) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                    bit_q   <= bit_q + 1'b1;
            end else sub_q <= sub_q + 1'b1;
          end
          ST_PAR: begin
            if (sub_q == BIT_LAST) begin
              sub_q     <= '0;
              pe_pend_q <= rx_s ^ par_bit(len_i, even_i, stick_i, aligned);
              state_q   <= ST_STOP;
            end else sub_q <= sub_q + 1'b1;
          end
          ST_STOP: begin
            if (sub_q == BIT_LAST) begin
              sub_q   <= '0;
              data_q  <= aligned;
              dr_q    <= 1'b1;
              pe_q    <= pe_pend_q;
              fe_q    <= ~rx_s;
              state_q <= ST_IDLE;
            end else sub_q <= sub_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign data_o = data_q;
  assign dr_o   = dr_q;
  assign pe_o   = pe_q;
  assign fe_o   = fe_q;

  assert_err_with_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fe_q) || $rose(pe_q)) |-> dr_q);

  assert_start_confirm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) == ST_START) |-> !$past(rx_s));

endmodule

// File: rtl/uart_line.sv
module uart_line
  import uart_line_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rx_i,
  output logic       tx_o
);

  localparam int DIV_BYTES = DIV_W / 8;

  lcr_t             lcr_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       ctrl_q;
  logic             tick;
  logic             div_load;
  logic             tx_wr;
  logic             thr_empty, tx_empty;
  logic [7:0]       rx_data;
  logic             rx_dr, rx_pe, rx_fe;
  logic             clr_dr, clr_err;
  logic [7:0]       lsr;

  assign div_load = wr_i && lcr_q.dlab && (addr_i == ADDR_DATA || addr_i == ADDR_CTRL);
  assign tx_wr    = wr_i && !lcr_q.dlab && (addr_i == ADDR_DATA);
  assign clr_dr   = rd_i && !lcr_q.dlab && (addr_i == ADDR_DATA);
  assign clr_err  = rd_i && (addr_i == ADDR_LSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q  <= '0;
      div_q  <= DIV_W'(1);
      ctrl_q <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADDR_DATA: if (lcr_q.dlab) div_q[7:0] <= wdata_i;
        ADDR_CTRL: if (lcr_q.dlab) div_q[15:8] <= wdata_i;
                   else            ctrl_q      <= wdata_i;
        ADDR_LCR:  lcr_q <= lcr_t'(wdata_i);
        default: ;
      endcase
    end
  end

  if (DIV_BYTES < 2) begin : g_div_chk
    initial $error("DIV_W must be at least 16");
  end

  assign lsr = {1'b0, tx_empty, thr_empty, 1'b0, rx_fe, rx_pe, 1'b0, rx_dr};

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = lcr_q.dlab ? div_q[7:0]  : rx_data;
      ADDR_CTRL: rdata_o = lcr_q.dlab ? div_q[15:8] : ctrl_q;
      ADDR_LCR:  rdata_o = lcr_q;
      ADDR_LSR:  rdata_o = lsr;
      default:   rdata_o = 8'h00;
    endcase
  end

  uart_line_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_q),
    .load_i (div_load),
    .tick_o (tick)
  );

  uart_line_tx #(.OVS(OVS)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .cfg_i       (lcr_q.fmt),
    .silence_i   (lcr_q.silence),
    .wr_i        (tx_wr),
    .wdata_i     (wdata_i),
    .line_o      (tx_o),
    .thr_empty_o (thr_empty),
    .tx_empty_o  (tx_empty)
  );

  uart_line_rx #(.OVS(OVS)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .rx_i      (rx_i),
    .len_i     (lcr_q.fmt.len),
    .par_en_i  (lcr_q.fmt.par_en),
    .even_i    (lcr_q.fmt.even),
    .stick_i   (lcr_q.fmt.stick),
    .clr_dr_i  (clr_dr),
    .clr_err_i (clr_err),
    .data_o    (rx_data),
    .dr_o      (rx_dr),
    .pe_o      (rx_pe),
    .fe_o      (rx_fe)
  );

  assert_div_lo_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_DATA && lcr_q.dlab) |=> (div_q[7:0] == $past(wdata_i)));

  assert_dlab_no_tx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_DATA && lcr_q.dlab && tx_empty) |=> tx_empty);

  assert_idle_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty && !lcr_q.silence) |-> tx_o);

  assert_silence_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_q.silence |-> !tx_o);

endmodule

// File: tb/tb_uart_line.sv
`timescale 1ns / 1ps
module tb_uart_line;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx = 1'b1;
  logic       tx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_line dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_i(rx), .tx_o(tx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic exp_par(input int pm, input logic [7:0] d, input int n);
    int ones;
    ones = $countones(d & 8'((1 << n) - 1));
    case (pm)
      1: return (ones % 2 == 0);   // odd
      2: return (ones % 2 == 1);   // even
      3: return 1'b1;              // fixed, even bit clear
      default: return 1'b0;        // fixed, even bit set
    endcase
  endfunction

  function automatic logic [7:0] par_field(input int pm);
    case (pm)
      1: return 8'h08;
      2: return 8'h18;
      3: return 8'h28;
      4: return 8'h38;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int stop_ticks(input int len, input int ms);
    if (ms == 0) return 16;
    return (len == 0) ? 24 : 32;
  endfunction

  // capture one transmitted frame by sampling at bit centres
  task automatic tx_frame(input int dv, input int len, input int pm, input int st,
                          input logic [7:0] d, input bit meas);
    int n, nb, el, t, tgt, tot;
    logic [7:0] got;
    logic v, st_lvl, pb, s1, s2;
    n = 5 + len; nb = 1 + n + (pm != 0 ? 1 : 0);
    got = '0; pb = 1'b0; s2 = 1'b1; st_lvl = 1'b1; s1 = 1'b0;
    t = 0;
    while (tx !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
    chk("R1 start seen", int'(t < 20000), 1);
    el = 0;
    for (int k = 0; k <= nb; k++) begin
      tgt = (16 * k + 8) * dv;
      repeat (tgt - el) @(negedge clk);
      el = tgt; v = tx;
      if (k == 0) st_lvl = v;
      else if (k <= n) got[k-1] = v;
      else if (k < nb) pb = v;
      else s1 = v;
    end
    if (st > 16) begin
      tgt = (16 * nb + st - 4) * dv;
      repeat (tgt - el) @(negedge clk);
      el = tgt; s2 = tx;
    end
    chk("R1 start level", int'(st_lvl), 0);
    chk("R1 data lsb first", int'(got), int'(d & 8'((1 << n) - 1)));
    if (pm == 1 || pm == 2) chk("R5 parity", int'(pb), int'(exp_par(pm, d, n)));
    if (pm >= 3)            chk("R6 fixed parity", int'(pb), int'(exp_par(pm, d, n)));
    chk("R2 stop level", int'({s1, s2}), 3);
    if (meas) begin
      addr = 3'd5; rd = 1'b1;
      #1;
      while (rdata[6] !== 1'b1 && el < 100000) begin @(negedge clk); #1; el++; end
      rd = 1'b0;
      tot = (16 * nb + st) * dv;
      chk("R2/R3 frame length", int'(el >= tot - dv - 1 && el <= tot + dv + 1), 1);
      if (!(el >= tot - dv - 1 && el <= tot + dv + 1))
        $display("  length detail: %0d vs %0d", el, tot);
    end
  endtask

  // drive one frame into rx; kind 0 clean, 1 parity flipped, 2 stop low
  task automatic rx_frame(input int dv, input int len, input int pm, input int st,
                          input logic [7:0] d, input int kind);
    int n;
    logic pb;
    logic [7:0] v;
    n = 5 + len;
    rx = 1'b0; repeat (16 * dv) @(negedge clk);
    for (int i = 0; i < n; i++) begin rx = d[i]; repeat (16 * dv) @(negedge clk); end
    if (pm != 0) begin
      pb = exp_par(pm, d, n);
      if (kind == 1) pb = ~pb;
      rx = pb; repeat (16 * dv) @(negedge clk);
    end
    if (kind == 2) begin
      rx = 1'b0; repeat (12 * dv) @(negedge clk);
      rx = 1'b1; repeat ((st - 12) * dv) @(negedge clk);
    end else begin
      rx = 1'b1; repeat (st * dv) @(negedge clk);
    end
    repeat (16 * dv) @(negedge clk);
    bus_rd(3'd5, v);
    chk("R9 status flags", int'(v),
        int'(8'h61 | ((kind == 1 && pm != 0) ? 8'h04 : 8'h00) | (kind == 2 ? 8'h08 : 8'h00)));
    bus_rd(3'd0, v);
    chk("R12 received data", int'(v), int'(d & 8'((1 << n) - 1)));
    bus_rd(3'd5, v);
    chk("R9 R12 flags cleared", int'(v), 32'h60);
  endtask

  initial begin
    logic [7:0] v;
    int idx, el, lowbad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    bus_rd(3'd3, v); chk("R13 lcr reset", int'(v), 0);
    bus_rd(3'd5, v); chk("R13 lsr reset", int'(v), 32'h60);
    chk("R13 tx idle high", int'(tx), 1);
    bus_wr(3'd3, 8'h80);
    bus_rd(3'd0, v); chk("R13 divisor low reset", int'(v), 1);
    bus_rd(3'd1, v); chk("R13 divisor high reset", int'(v), 0);

    // R4 divisor access switch
    bus_wr(3'd0, 8'h34);
    bus_wr(3'd1, 8'h12);
    bus_rd(3'd0, v); chk("R4 divisor low", int'(v), 32'h34);
    bus_rd(3'd1, v); chk("R4 divisor high", int'(v), 32'h12);
    repeat (4) @(negedge clk);
    bus_rd(3'd5, v); chk("R4 no tx from divisor write", int'(v), 32'h60);
    bus_wr(3'd3, 8'h03);
    bus_rd(3'd3, v); chk("R13 lcr readback", int'(v), 3);
    bus_wr(3'd1, 8'hA5);
    bus_rd(3'd1, v); chk("R4 ctrl storage", int'(v), 32'hA5);
    bus_wr(3'd3, 8'h83);
    bus_rd(3'd0, v); chk("R4 divisor kept low", int'(v), 32'h34);
    bus_rd(3'd1, v); chk("R4 divisor kept high", int'(v), 32'h12);
    bus_wr(3'd0, 8'h02);
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd3, 8'h03);

    // transmit sweep: R1 R2 R5 R6
    idx = 0;
    for (int len = 0; len < 4; len++)
      for (int pm = 0; pm < 5; pm++)
        for (int ms = 0; ms < 2; ms++) begin
          v = 8'h5A ^ 8'(idx * 29);
          bus_wr(3'd3, 8'(len) | 8'(ms << 2) | par_field(pm));
          bus_wr(3'd0, v);
          tx_frame(2, len, pm, stop_ticks(len, ms), v, 1'b1);
          idx++;
        end

    // receive sweep: R8 R9 R12, fixed parity check R6
    idx = 0;
    for (int len = 0; len < 4; len++)
      for (int pm = 0; pm < 5; pm++)
        for (int ms = 0; ms < 2; ms++) begin
          v = 8'hC3 ^ 8'(idx * 53);
          bus_wr(3'd3, 8'(len) | 8'(ms << 2) | par_field(pm));
          rx_frame(2, len, pm, stop_ticks(len, ms), v, idx % 3);
          idx++;
        end

    // R8 short low pulse rejected
    bus_wr(3'd3, 8'h03);
    rx = 1'b0; repeat (8) @(negedge clk);
    rx = 1'b1; repeat (80) @(negedge clk);
    bus_rd(3'd5, v); chk("R8 glitch rejected", int'(v), 32'h60);

    // R11 R10 holding register behind a busy shifter
    bus_wr(3'd0, 8'h96);
    bus_wr(3'd0, 8'h3C);
    bus_rd(3'd5, v); chk("R10 both busy", int'(v), 0);
    tx_frame(2, 3, 0, 16, 8'h96, 1'b0);
    tx_frame(2, 3, 0, 16, 8'h3C, 1'b1);
    bus_rd(3'd5, v); chk("R10 empty after frames", int'(v), 32'h60);

    // R7 silence: line low, frame still takes its full time
    bus_wr(3'd3, 8'h43);
    bus_wr(3'd0, 8'hFF);
    el = 0; lowbad = 0;
    addr = 3'd5; rd = 1'b1;
    #1;
    while (rdata[6] !== 1'b1 && el < 100000) begin
      if (tx !== 1'b0) lowbad++;
      @(negedge clk); #1; el++;
    end
    rd = 1'b0;
    chk("R7 line held low", lowbad, 0);
    chk("R7 shifter timing kept", int'(el >= 160 * 2 - 2 && el <= 160 * 2 + 4), 1);
    bus_wr(3'd3, 8'h03);
    #1 chk("R7 line released", int'(tx), 1);

    // R3 other divisor value
    bus_wr(3'd3, 8'h83);
    bus_wr(3'd0, 8'h03);
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd3, 8'h1B);
    bus_wr(3'd0, 8'h71);
    tx_frame(3, 3, 2, 16, 8'h71, 1'b1);
    rx_frame(3, 3, 2, 16, 8'hE4, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule